// File: doc/BRIEF.md
# Cascadable Column Data Capture Front End

This block is the digital intake for one slice of a display column driver with 384 outputs. Every rising clock edge delivers a 36-bit word made of six 6-bit dot codes. An internal pointer walks across 64 groups of six outputs and writes each incoming word into the group it currently selects. The pointer can run in either direction. When it reaches its last group, the block raises a one-cycle start pulse so that the next slice in a chain begins filling on the following edge.

A strobe rising edge copies the filled data register into a line latch, and the latch drives the block's output. The same edge returns the pointer to idle. An inversion input can complement every dot code before it is stored.

After 66 clocks the block stops capturing on its own. It then ignores further clocks and start pulses until the next strobe. The strobe is sampled on the clock, so its rising edge is seen at the first clock edge where it reads high after reading low.

Top module: `column_capture`

## Requirements
- R1: While rst_n is low at a clock edge, the following edge leaves every code output at 0, both start outputs low and the pointer idle.
- R2: Dot j of a word is din[6j+5:6j], with bit 0 as the LSB. The word is captured on a rising clock edge. Output k (numbered 0 to 383) is codes[6k+5:6k], and group p covers outputs 6p to 6p+5, with dot j going to output 6p+j.
- R3: With dir high when the start is accepted, the start comes from start_r_in. The n-th captured word (n from 0) goes to group n, and the cascade pulse appears on start_l_out while start_r_out stays low.
- R4: With dir low when the start is accepted, the start comes from start_l_in. The n-th captured word goes to group 63-n, and the cascade pulse appears on start_r_out while start_l_out stays low.
- R5: A start seen high at a rising edge while the block is idle is accepted on that edge, and that same edge captures the first group.
- R6: The cascade start output is high for exactly one cycle, beginning at the 64th clock edge counted from the accepting edge, which is the edge that captures the last group.
- R7: Once 66 clock edges have been counted from the accepting edge, the data register no longer changes and start inputs are ignored until a strobe rising edge.
- R8: On a strobe rising edge the line latch takes the data register contents and the pointer returns to idle. Holding the strobe high on later edges has no further effect.
- R9: With inv high at the capturing edge, each stored dot code is the bitwise complement of the input code. With inv low, the code is stored unchanged.
- R10: A start input that is high while the pointer is running is ignored.
- R11: The code outputs change only on a strobe rising edge or under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | Fill direction: 1 fills upward from group 0, 0 fills downward from group 63 |
| start_r_in | input | 1 | Start input used when dir is high |
| start_l_in | input | 1 | Start input used when dir is low |
| inv | input | 1 | Complement the dot codes before storing them |
| strobe | input | 1 | Line strobe; its rising edge latches the line and clears the pointer |
| din | input | 36 | Six 6-bit dot codes |
| start_r_out | output | 1 | Cascade start output for downward fill |
| start_l_out | output | 1 | Cascade start output for upward fill |
| codes | output | 2304 | Latched 6-bit code for each of the 384 outputs |

## Verification
The bench fills complete lines in both directions, with and without inversion, using arithmetic data patterns. It compares all 384 latched codes after each strobe. A pointer that reverses the group order or the dot order would scramble outputs, and a cascade pulse that is one cycle early, one cycle late or on the wrong pin is caught by cycle-exact sampling. The bench also raises a start while a line is filling and again after the halt. A design that restarts on either of those would overwrite group data. It further checks that the outputs hold until the strobe, which catches a latch that follows the data register.

// File: rtl/column_capture.sv
module column_capture #(
  parameter int GROUPS = 64,
  parameter int DOTS   = 6,
  parameter int BITS   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dir,
  input  logic                          start_r_in,
  input  logic                          start_l_in,
  input  logic                          inv,
  input  logic                          strobe,
  input  logic [DOTS*BITS-1:0]          din,
  output logic                          start_r_out,
  output logic                          start_l_out,
  output logic [GROUPS*DOTS*BITS-1:0]   codes
);
  localparam int W    = DOTS * BITS;
  localparam int HALT = GROUPS + 2;
  localparam int CW   = $clog2(HALT + 1);
  localparam logic [CW-1:0] LAST = CW'(GROUPS - 1);
  localparam logic [CW-1:0] STOP = CW'(HALT - 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic                dir_q, pulse, stb_q;
  logic [GROUPS*W-1:0] dreg;

  wire           stb_rise = strobe & ~stb_q;
  wire           start_in = dir ? start_r_in : start_l_in;
  wire           accept   = (st == IDLE) && start_in && !stb_rise;
  wire           capture  = !stb_rise && (accept || (st == RUN && cnt < CW'(GROUPS)));
  wire [W-1:0]   word     = inv ? ~din : din;
  wire           cap_dir  = accept ? dir : dir_q;
  wire [CW-1:0]  idx      = accept ? '0 : cnt;
  wire [CW-1:0]  phys     = cap_dir ? idx : LAST - idx;

  assign start_l_out = pulse & dir_q;
  assign start_r_out = pulse & ~dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      dir_q <= 1'b0;
      pulse <= 1'b0;
      stb_q <= 1'b0;
      dreg  <= '0;
      codes <= '0;
    end else begin
      stb_q <= strobe;
      pulse <= 1'b0;
      if (stb_rise) begin
        codes <= dreg;
        st    <= IDLE;
        cnt   <= '0;
      end else begin
        case (st)
          IDLE: if (start_in) begin
            st    <= RUN;
            cnt   <= CW'(1);
            dir_q <= dir;
          end
          RUN: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) pulse <= 1'b1;
            if (cnt == STOP) st <= DONE;
          end
          default: ;
        endcase
      end
      if (capture) dreg[int'(phys)*W +: W] <= word;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (codes == '0 && !start_l_out && !start_r_out && st == IDLE));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  a_r6_pulse_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && cnt == LAST && !stb_rise) |=> (start_l_out || start_r_out));

  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DONE && !stb_rise) |=> (st == DONE && $stable(dreg)));

  a_r8_strobe_latch: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> (codes == $past(dreg) && st == IDLE));

  a_r11_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(codes));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && cnt != STOP && !stb_rise) |=> (st == RUN && cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/sim_column_capture.sv
module sim_column_capture;
  localparam int G = 64;
  localparam int D = 6;
  localparam int B = 6;
  localparam int N = G * D;

  logic clk = 0;
  logic rst_n, dir, start_r_in, start_l_in, inv, strobe;
  logic [D*B-1:0] din;
  logic start_r_out, start_l_out;
  logic [N*B-1:0] codes;

  logic [B-1:0] mdl [N];
  logic [B-1:0] expl [N];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  column_capture u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir), .start_r_in(start_r_in),
    .start_l_in(start_l_in), .inv(inv), .strobe(strobe), .din(din),
    .start_r_out(start_r_out), .start_l_out(start_l_out), .codes(codes)
  );

  function automatic logic [D*B-1:0] pat(int lno, int g, logic dv);
    logic [D*B-1:0] w;
    for (int j = 0; j < D; j++)
      w[j*B +: B] = B'((lno * 37 + g * 7 + j * 11 + (dv ? 0 : 5)) % 64);
    return w;
  endfunction

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_line(string req);
    for (int k = 0; k < N; k++)
      chk(codes[k*B +: B] == expl[k], req, int'(codes[k*B +: B]), int'(expl[k]));
  endtask

  task automatic run_line(logic dv, logic iv, int lno, int mode);
    for (int g = 0; g < G; g++) begin
      @(negedge clk);
      if (g == G - 1)
        chk(!start_l_out && !start_r_out, "R6 early pulse", int'({start_l_out, start_r_out}), 0);
      dir = dv;
      inv = iv;
      start_r_in = dv && (g == 0 || (mode == 1 && g == 10));
      start_l_in = !dv && (g == 0 || (mode == 1 && g == 10));
      din = pat(lno, g, dv);
      for (int j = 0; j < D; j++)
        mdl[(dv ? g : G - 1 - g) * D + j] = iv ? ~din[j*B +: B] : din[j*B +: B];
    end
    @(negedge clk);
    if (dv) begin
      chk(start_l_out == 1'b1, "R3 R6 pulse on left out", int'(start_l_out), 1);
      chk(start_r_out == 1'b0, "R3 right out quiet", int'(start_r_out), 0);
    end else begin
      chk(start_r_out == 1'b1, "R4 R6 pulse on right out", int'(start_r_out), 1);
      chk(start_l_out == 1'b0, "R4 left out quiet", int'(start_l_out), 0);
    end
    start_r_in = 0;
    start_l_in = 0;
    din = 36'hA_BCDE_1234;
    @(negedge clk);
    chk(!start_l_out && !start_r_out, "R6 pulse one cycle", int'({start_l_out, start_r_out}), 0);
    din = 36'h5_A5A5_A5A5;
    @(negedge clk);
    if (mode == 2) begin
      for (int t = 0; t < 3; t++) begin
        start_r_in = 1;
        start_l_in = 1;
        din = 36'hF_0F0F_0F0F;
        @(negedge clk);
      end
      start_r_in = 0;
      start_l_in = 0;
      @(negedge clk);
    end
    cmp_line("R11 hold before strobe");
    strobe = 1;
    @(negedge clk);
    for (int k = 0; k < N; k++) expl[k] = mdl[k];
    cmp_line(mode == 1 ? "R10 R2 line" : (mode == 2 ? "R7 R2 line" :
             (iv ? "R9 R2 line" : (dv ? "R3 R5 R2 line" : "R4 R5 R2 line"))));
    @(negedge clk);
    cmp_line("R8 strobe held");
    strobe = 0;
  endtask

  initial begin
    rst_n = 0; dir = 1; start_r_in = 0; start_l_in = 0; inv = 0; strobe = 0; din = '0;
    for (int k = 0; k < N; k++) begin mdl[k] = '0; expl[k] = '0; end
    repeat (3) @(negedge clk);
    cmp_line("R1 reset codes");
    chk(!start_l_out && !start_r_out, "R1 reset pulses", int'({start_l_out, start_r_out}), 0);
    rst_n = 1;
    run_line(1'b1, 1'b0, 1, 0);
    run_line(1'b0, 1'b0, 2, 0);
    run_line(1'b1, 1'b1, 3, 0);
    run_line(1'b0, 1'b1, 4, 0);
    run_line(1'b1, 1'b0, 5, 1);
    run_line(1'b0, 1'b0, 6, 1);
    run_line(1'b1, 1'b1, 7, 2);
    run_line(1'b0, 1'b0, 8, 2);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    for (int k = 0; k < N; k++) expl[k] = '0;
    cmp_line("R1 reset after use");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule